// File: doc/BRIEF.md
# Write Enable and Region Protection Unit

This block owns the eight-bit status byte of a serial nonvolatile memory and decides, one request at a time, whether a write may go ahead. A command decoder upstream raises single-cycle strobes for arming or disarming writes, setting or clearing a user flag, and starting or finishing an internal write cycle. It also presents the target of the pending write: an array address, or a marker that says the status byte itself is the target. The block answers with a combinational permit and keeps the status byte current for the read path.

A write needs three things. The enable latch must be armed. No internal write may be in progress. The target must not be locked. Array locations are locked by a two-bit region select that covers nothing, the top quarter, the top half or the whole address space. The status byte is locked when its pin-lock bit is set and the write-protect pin is driven low. Bits that would normally sit in nonvolatile cells are ordinary flops here. They load a parameterised default at reset.

Top module: `wprot_unit`

## Requirements
- R1: After reset, bits 7:2 of the status byte equal the default parameter's bits 7:2. Bit 1 (enable latch) and bit 0 (busy) read 0.
- R2: While idle, `arm_i` sets status bit 1 in the next cycle and `disarm_i` clears it. If both are high, `disarm_i` wins.
- R3: While bit 1 is 0, `permit_o` is 0 for every target. A `start_i` then leaves the status byte unchanged.
- R4: Status bits 3:2 select the locked array region. 00 locks nothing. 01 locks addresses in the top quarter (the two address MSBs are 11). 10 locks the top half (MSB 1). 11 locks everything. A locked array target gives `permit_o` = 0.
- R5: A `start_i` with `permit_o` = 1 sets status bit 0 in the next cycle. While bit 0 is 1, `permit_o` is 0, and every strobe except `done_i` has no effect on the status byte.
- R6: `done_i` while busy clears both bit 0 and bit 1 in the next cycle.
- R7: An accepted status write (`to_status_i` = 1) copies `wdata_i[7:2]` into status bits 7:2 in the next cycle. Bits 1:0 do not follow `wdata_i`.
- R8: When status bit 7 is 1 and `wp_n_i` is 0, status writes get `permit_o` = 0. Array writes are still judged by R4.
- R9: When status bit 7 is 0 or `wp_n_i` is 1, a status write with bit 1 set and bit 0 clear gets `permit_o` = 1.
- R10: While idle, `flag_set_i` sets status bit 6 and `flag_clr_i` clears it, whatever the value of bit 1. If both are high, `flag_clr_i` wins.
- R11: A `start_i` with `permit_o` = 0 does not set bit 0. It does not change bit 1 apart from a `disarm_i` or `arm_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Set the enable latch |
| disarm_i | input | 1 | Clear the enable latch |
| flag_set_i | input | 1 | Set the user flag |
| flag_clr_i | input | 1 | Clear the user flag |
| start_i | input | 1 | Begin a write cycle on the presented target |
| done_i | input | 1 | Internal write cycle finished |
| wp_n_i | input | 1 | Write-protect pin, active low |
| to_status_i | input | 1 | Target is the status byte |
| addr_i | input | AW | Target array address |
| wdata_i | input | 8 | New status value for a status write |
| permit_o | output | 1 | Presented write is allowed |
| status_o | output | 8 | Status byte: lock-enable, flag, two watchdog bits, two region bits, enable latch, busy |

## Verification
The permit is tried with every region setting against addresses at both edges of each quarter. This tells a correct MSB decode apart from an off-by-one or inverted boundary. Status writes are tried with all four combinations of the lock-enable bit and pin level, so that the pin lock is separated from the region lock. Arming, flag and start strobes are also applied while the block is busy and while it is disarmed, which shows whether busy or the latch is the gate that refuses them. A stretch of random single-strobe traffic then exercises interleavings that the directed steps miss.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
   localparam int SB_WIDTH = 8;
   localparam int B_LOCK   = 7;
   localparam int B_FLAG   = 6;
   localparam int B_WDH    = 5;
   localparam int B_WDL    = 4;
   localparam int B_RGH    = 3;
   localparam int B_RGL    = 2;
   localparam int B_ARM    = 1;
   localparam int B_BUSY   = 0;

   typedef struct packed {
      logic       lock_en;
      logic       flag;
      logic [1:0] wdog;
      logic [1:0] region;
      logic       armed;
      logic       busy;
   } stat_t;

   typedef enum logic [1:0] {
      RG_NONE    = 2'b00,
      RG_QUARTER = 2'b01,
      RG_HALF    = 2'b10,
      RG_ALL     = 2'b11
   } region_e;
endpackage

// File: rtl/wprot_region_dec.sv
module wprot_region_dec
   import wprot_pkg::*;
#(
   parameter int AW       = 8,
   parameter bit PROT_TOP = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    region,
   output logic          locked
);
   localparam int MSB = AW - 1;

   logic q_hit;
   logic h_hit;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("wprot_region_dec: AW must be at least 2");
      end
      if (PROT_TOP) begin : g_top
         assign q_hit = (addr[MSB:MSB-1] == 2'b11);
         assign h_hit = addr[MSB];
      end else begin : g_bottom
         assign q_hit = (addr[MSB:MSB-1] == 2'b00);
         assign h_hit = ~addr[MSB];
      end
   endgenerate

   always_comb begin
      unique case (region_e'(region))
         RG_NONE:    locked = 1'b0;
         RG_QUARTER: locked = q_hit;
         RG_HALF:    locked = h_hit;
         default:    locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/wprot_status_reg.sv
module wprot_status_reg
   import wprot_pkg::*;
#(
   parameter logic [7:0] ST_INIT = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       disarm,
   input  logic       flag_set,
   input  logic       flag_clr,
   input  logic       accept,
   input  logic       to_status,
   input  logic       done,
   input  logic [7:0] wdata,
   output stat_t      st
);
   localparam logic [7:0] INIT_MASKED = ST_INIT & 8'hFC;

   stat_t st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= stat_t'(INIT_MASKED);
      end else if (st_q.busy) begin
         if (done) begin
            st_q.busy  <= 1'b0;
            st_q.armed <= 1'b0;
         end
      end else if (accept) begin
         st_q.busy <= 1'b1;
         if (to_status) begin
            st_q.lock_en <= wdata[B_LOCK];
            st_q.flag    <= wdata[B_FLAG];
            st_q.wdog    <= wdata[B_WDH:B_WDL];
            st_q.region  <= wdata[B_RGH:B_RGL];
         end
      end else begin
         if (disarm)        st_q.armed <= 1'b0;
         else if (arm)      st_q.armed <= 1'b1;
         if (flag_clr)      st_q.flag  <= 1'b0;
         else if (flag_set) st_q.flag  <= 1'b1;
      end
   end

   assign st = st_q;

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.busy && done) |=> (!st_q.busy && !st_q.armed)); // R6
   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.busy && !done) |=> $stable(st_q)); // R5
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q.busy && accept) |=> st_q.busy); // R5
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
   import wprot_pkg::*;
#(
   parameter int         AW       = 8,
   parameter bit         PROT_TOP = 1'b1,
   parameter logic [7:0] ST_INIT  = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic          disarm_i,
   input  logic          flag_set_i,
   input  logic          flag_clr_i,
   input  logic          start_i,
   input  logic          done_i,
   input  logic          wp_n_i,
   input  logic          to_status_i,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    wdata_i,
   output logic          permit_o,
   output logic [7:0]    status_o
);
   stat_t st;
   logic  arr_locked;
   logic  st_locked;
   logic  target_ok;
   logic  accept;

   generate
      if ($bits(stat_t) != SB_WIDTH) begin : g_bad_width
         $error("wprot_unit: status struct width mismatch");
      end
   endgenerate

   wprot_region_dec #(.AW(AW), .PROT_TOP(PROT_TOP)) u_dec (
      .addr   (addr_i),
      .region (st.region),
      .locked (arr_locked)
   );

   assign st_locked = st.lock_en & ~wp_n_i;
   assign target_ok = to_status_i ? ~st_locked : ~arr_locked;
   assign permit_o  = st.armed & ~st.busy & target_ok;
   assign accept    = start_i & permit_o;

   wprot_status_reg #(.ST_INIT(ST_INIT)) u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm_i),
      .disarm    (disarm_i),
      .flag_set  (flag_set_i),
      .flag_clr  (flag_clr_i),
      .accept    (accept),
      .to_status (to_status_i),
      .done      (done_i),
      .wdata     (wdata_i),
      .st        (st)
   );

   assign status_o = st;

   AST_NO_ARM_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[B_ARM] |-> !permit_o); // R3
   AST_BUSY_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[B_BUSY] |-> !permit_o); // R5
   AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[B_RGH:B_RGL] == 2'b11 && !to_status_i) |-> !permit_o); // R4
   AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[B_LOCK] && !wp_n_i && to_status_i) |-> !permit_o); // R8
   AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !permit_o && !status_o[B_BUSY] && !arm_i && !disarm_i)
      |=> ($stable(status_o[B_ARM]) && !status_o[B_BUSY])); // R11
endmodule

// File: tb/wprot_unit_test.sv
module wprot_unit_test;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm_i = 0, disarm_i = 0, flag_set_i = 0, flag_clr_i = 0;
   logic start_i = 0, done_i = 0, wp_n_i = 1, to_status_i = 0;
   logic [AW-1:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic permit_o;
   logic [7:0] status_o;

   int checks = 0;
   int fails = 0;
   int m_lock, m_flag, m_wd, m_rg, m_arm, m_busy;

   always #5 clk = ~clk;

   wprot_unit #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
      .flag_set_i(flag_set_i), .flag_clr_i(flag_clr_i), .start_i(start_i),
      .done_i(done_i), .wp_n_i(wp_n_i), .to_status_i(to_status_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .permit_o(permit_o),
      .status_o(status_o)
   );

   function automatic int model_permit();
      int a;
      a = int'(addr_i);
      if (m_busy == 1 || m_arm == 0) return 0;
      if (to_status_i) return (m_lock == 1 && wp_n_i == 0) ? 0 : 1;
      case (m_rg)
         0: return 1;
         1: return (a < 192) ? 1 : 0;
         2: return (a < 128) ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] model_status();
      return {1'(m_lock), 1'(m_flag), 2'(m_wd), 2'(m_rg), 1'(m_arm), 1'(m_busy)};
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(string tag);
      int p;
      #1;
      p = model_permit();
      check({tag, " status"}, status_o, model_status());
      check({tag, " permit"}, {7'd0, permit_o}, 8'(p));
      if (m_busy == 1) begin
         if (done_i) begin m_busy = 0; m_arm = 0; end
      end else if (start_i && p == 1) begin
         m_busy = 1;
         if (to_status_i) begin
            m_lock = wdata_i[7]; m_flag = wdata_i[6];
            m_wd = wdata_i[5:4]; m_rg = wdata_i[3:2];
         end
      end else begin
         if (disarm_i) m_arm = 0; else if (arm_i) m_arm = 1;
         if (flag_clr_i) m_flag = 0; else if (flag_set_i) m_flag = 1;
      end
      @(posedge clk);
      @(negedge clk);
      arm_i = 0; disarm_i = 0; flag_set_i = 0; flag_clr_i = 0;
      start_i = 0; done_i = 0;
   endtask

   task automatic wr_status(logic [7:0] v, string tag);
      arm_i = 1; tick({tag, " arm"});
      to_status_i = 1; wdata_i = v; start_i = 1; tick(tag);
      to_status_i = 0; done_i = 1; tick({tag, " done"});
   endtask

   initial begin
      m_lock = 0; m_flag = 0; m_wd = 0; m_rg = 0; m_arm = 0; m_busy = 0;
      repeat (3) @(negedge clk);
      check("R1 reset", status_o, 8'h00);
      rst_n = 1;
      tick("R1 after reset");

      arm_i = 1; tick("R2 arm");
      disarm_i = 1; tick("R2 disarm");
      arm_i = 1; disarm_i = 1; tick("R2 both");

      addr_i = 8'h10; start_i = 1; tick("R3 disarmed start");
      to_status_i = 1; start_i = 1; wdata_i = 8'hFC; tick("R3 disarmed status");
      to_status_i = 0;

      flag_set_i = 1; tick("R10 flag set");
      flag_clr_i = 1; flag_set_i = 1; tick("R10 flag both");

      arm_i = 1; tick("R5 arm");
      addr_i = 8'hFF; start_i = 1; tick("R5 start");
      arm_i = 1; flag_set_i = 1; start_i = 1; tick("R5 busy ignore");
      disarm_i = 1; tick("R5 busy disarm ignored");
      done_i = 1; tick("R6 done");
      tick("R6 after");

      wr_status(8'b0011_0100, "R7 wdog+quarter");
      arm_i = 1; tick("R4 arm");
      for (int rg = 0; rg < 4; rg++) begin
         if (rg != 1) begin
            wr_status(8'(rg << 2) | 8'h03, "R7 region");
            arm_i = 1; tick("R4 rearm");
         end
         foreach (addr_i[i]) begin end
         for (int k = 0; k < 8; k++) begin
            logic [7:0] edges [8] = '{8'h00, 8'h3F, 8'h40, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
            addr_i = edges[k];
            tick("R4 probe");
         end
         start_i = 1; addr_i = 8'hC8; tick("R11 locked start");
         if (m_busy == 1) begin done_i = 1; tick("R6 done"); end
      end

      wr_status(8'b1000_0000, "R7 set lock-en");
      for (int w = 0; w < 2; w++) begin
         wp_n_i = 1'(w); arm_i = 1; tick("R8 arm");
         to_status_i = 1; tick("R8 R9 probe");
         to_status_i = 0; addr_i = 8'h05; tick("R8 array");
      end
      wp_n_i = 0; to_status_i = 1; wdata_i = 8'h00; start_i = 1;
      tick("R11 pin-locked start");
      to_status_i = 0;

      for (int n = 0; n < 300; n++) begin
         int s;
         s = $urandom_range(0, 7);
         wp_n_i = 1'($urandom_range(0, 1));
         to_status_i = 1'($urandom_range(0, 1));
         addr_i = 8'($urandom);
         wdata_i = 8'($urandom);
         case (s)
            0: arm_i = 1;
            1: disarm_i = 1;
            2: flag_set_i = 1;
            3: flag_clr_i = 1;
            4, 5: start_i = 1;
            6: done_i = 1;
            default: ;
         endcase
         tick("R9 R11 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule